// File: doc/BRIEF.md
# Tri-State Phase-Frequency Detector Controller

This block compares a reference pulse stream against a divided feedback pulse stream for one synthesizer channel and decides, every cycle of a fast sampling clock, whether the external charge pump should source current, sink current or stay at high impedance. It uses two pending flags, one for each stream. A rising edge on a stream raises that stream's flag. When both flags are high for a fixed number of cycles, both flags are cleared. A stream that leads in phase or in frequency keeps its flag high until the other stream produces an edge. This gives a detection range of a full cycle either way.

Both flags are always held high together for a short window, even when the two edges arrive in the same cycle. This keeps the loop out of a dead zone near lock. A polarity input sets which pump direction corresponds to a leading reference. A forced tri-state input or a power-save input makes the output high impedance. Power save also clears the detector and the lock state. A lock monitor counts consecutive comparisons whose one-sided pump time stays small. The current-scale select input is passed through to the pump.

Top module: `pfd_ctrl`

## Requirements
- R1: With `polarity_i`=1, a reference edge that arrives before the feedback edge asserts `pump_up_o` alone from the cycle after that edge until the feedback edge arrives. A feedback edge that arrives first asserts `pump_dn_o` alone in the same way.
- R2: With `polarity_i`=0, the two directions are swapped. A leading reference asserts `pump_dn_o` alone, and a leading feedback asserts `pump_up_o` alone.
- R3: After reset, and whenever no comparison is pending, `hiz_o`=1, both pump outputs are 0 and `lock_o`=0 (after reset).
- R4: Further reference edges that arrive while a reference-led pulse is still pending are absorbed. The one-sided pulse stays high without a gap until a feedback edge arrives.
- R5: When the second flag is set, both pump outputs are high for exactly MIN_OVL cycles (default 2) with `hiz_o`=0, and then both are cleared. This also applies to edges that arrive in the same cycle.
- R6: `force_z_i`=1 holds `hiz_o`=1 and both pump outputs at 0. The detector and the lock monitor keep running, so `lock_o` is unaffected.
- R7: `pwr_save_i`=1 holds `hiz_o`=1, both pump outputs at 0 and `lock_o`=0. It clears any pending pulse, so that after release the output stays high impedance until a new edge arrives.
- R8: `cur_x4_o` equals `cur_sel_i` (1 selects 4x pump current, 0 selects 1x).
- R9: `lock_o` rises at the end of the LOCK_CNT-th (default 4) consecutive comparison in which the number of one-sided pump cycles is at most LOCK_THR (default 2). A comparison ends when both flags clear.
- R10: `lock_o` falls, and the good-comparison count restarts, in the cycle in which the one-sided pump time of the current comparison exceeds LOCK_THR.
- R11: Whenever `hiz_o`=1, neither `pump_up_o` nor `pump_dn_o` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Reference pulse stream |
| fb_i | input | 1 | Divided feedback pulse stream |
| polarity_i | input | 1 | 1: a leading reference sources, 0: a leading reference sinks |
| cur_sel_i | input | 1 | Pump current select, 1 for 4x |
| force_z_i | input | 1 | Force the pump output to high impedance |
| pwr_save_i | input | 1 | Power save: high impedance, detector and lock cleared |
| pump_up_o | output | 1 | Source-current enable |
| pump_dn_o | output | 1 | Sink-current enable |
| hiz_o | output | 1 | Pump output is high impedance |
| cur_x4_o | output | 1 | Current-scale flag |
| lock_o | output | 1 | Lock detect |

## Verification
The hardest situations to reach are the two edges of the lock threshold. A comparison whose one-sided time equals LOCK_THR must keep lock. One that is a single cycle longer must drop lock and restart the consecutive count. The stimulus builds lock with aligned periods and then applies a two-cycle lead followed by a three-cycle lead. It then shows that three good periods are not enough to relock and that a fourth one is. A pending one-sided pulse that is still open when power save is entered is produced by a reference-only period just before power save, so that a missing clear on release would show up as a pump output.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pfd_flags_t;
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_OVL = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_rise_i,
  input  logic       fb_rise_i,
  input  logic       hold_i,
  output pfd_flags_t flags_o,
  output logic       cmp_done_o
);
  localparam int unsigned OVL_W = (MIN_OVL < 2) ? 1 : $clog2(MIN_OVL);
  localparam logic [OVL_W-1:0] OVL_LAST = OVL_W'(MIN_OVL - 1);

  logic             up_q, dn_q;
  logic [OVL_W-1:0] ovl_q;
  logic             both, clr;

  assign both = up_q & dn_q;
  assign clr  = both && (ovl_q == OVL_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      ovl_q <= '0;
    end else if (hold_i) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      ovl_q <= '0;
    end else begin
      // a new edge in the clearing cycle starts the next comparison
      up_q  <= clr ? ref_rise_i : (up_q | ref_rise_i);
      dn_q  <= clr ? fb_rise_i  : (dn_q | fb_rise_i);
      ovl_q <= (both && !clr) ? ovl_q + 1'b1 : '0;
    end
  end

  assign flags_o.up = up_q;
  assign flags_o.dn = dn_q;
  assign cmp_done_o = clr;

  // R4: a lone pending flag is never dropped while running
  p_up_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && !dn_q && !hold_i) |=> up_q);
  p_dn_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_q && !up_q && !hold_i) |=> dn_q);

  generate
    if (MIN_OVL > 1) begin : g_ovl_chk
      // R5: overlap lasts more than one cycle
      p_min_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || hold_i)
        (both && !$past(both)) |=> (up_q && dn_q));
    end
  endgenerate

  // R7: power save empties the detector
  p_hold_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (!up_q && !dn_q));
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
  import pfd_pkg::*;
#(
  parameter int unsigned LOCK_THR = 2,
  parameter int unsigned LOCK_CNT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pfd_flags_t flags_i,
  input  logic       cmp_done_i,
  input  logic       hold_i,
  output logic       lock_o
);
  localparam int unsigned WID_W = $clog2(LOCK_THR + 2);
  localparam int unsigned GD_W  = $clog2(LOCK_CNT + 1);
  localparam logic [WID_W-1:0] WID_MAX = WID_W'(LOCK_THR + 1);
  localparam logic [WID_W-1:0] THR     = WID_W'(LOCK_THR);
  localparam logic [GD_W-1:0]  GD_LAST = GD_W'(LOCK_CNT - 1);

  logic [WID_W-1:0] wid_q;
  logic [GD_W-1:0]  good_q;
  logic             bad_q, lock_q;
  logic             single, over;

  assign single = flags_i.up ^ flags_i.dn;
  assign over   = single && (wid_q >= THR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_q  <= '0;
      good_q <= '0;
      bad_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (hold_i) begin
      wid_q  <= '0;
      good_q <= '0;
      bad_q  <= 1'b0;
      lock_q <= 1'b0;
    end else if (cmp_done_i) begin
      wid_q <= '0;
      bad_q <= 1'b0;
      if (!bad_q) begin
        if (good_q >= GD_LAST) begin
          good_q <= GD_W'(LOCK_CNT);
          lock_q <= 1'b1;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end else begin
      if (single && wid_q != WID_MAX) wid_q <= wid_q + 1'b1;
      if (over) begin
        bad_q  <= 1'b1;
        good_q <= '0;
        lock_q <= 1'b0;
      end
    end
  end

  assign lock_o = lock_q;

  // R9: lock only rises when a comparison completes
  p_lock_at_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(cmp_done_i));
  // R10: an over-long one-sided pulse drops lock next cycle
  p_over_unlocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over && !hold_i) |=> !lock_q);
endmodule

// File: rtl/pfd_ctrl.sv
module pfd_ctrl
  import pfd_pkg::*;
#(
  parameter int unsigned MIN_OVL  = 2,
  parameter int unsigned LOCK_THR = 2,
  parameter int unsigned LOCK_CNT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic fb_i,
  input  logic polarity_i,
  input  logic cur_sel_i,
  input  logic force_z_i,
  input  logic pwr_save_i,
  output logic pump_up_o,
  output logic pump_dn_o,
  output logic hiz_o,
  output logic cur_x4_o,
  output logic lock_o
);
  logic       ref_rise, fb_rise, cmp_done, drive_en;
  pfd_flags_t flags;

  pfd_edge i_ref_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .sig_i (ref_i), .rise_o (ref_rise)
  );
  pfd_edge i_fb_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .sig_i (fb_i), .rise_o (fb_rise)
  );

  pfd_core #(.MIN_OVL(MIN_OVL)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_rise_i (ref_rise),
    .fb_rise_i  (fb_rise),
    .hold_i     (pwr_save_i),
    .flags_o    (flags),
    .cmp_done_o (cmp_done)
  );

  pfd_lock #(.LOCK_THR(LOCK_THR), .LOCK_CNT(LOCK_CNT)) i_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flags_i    (flags),
    .cmp_done_i (cmp_done),
    .hold_i     (pwr_save_i),
    .lock_o     (lock_o)
  );

  assign drive_en  = ~(force_z_i | pwr_save_i);
  assign pump_up_o = drive_en & (polarity_i ? flags.up : flags.dn);
  assign pump_dn_o = drive_en & (polarity_i ? flags.dn : flags.up);
  assign hiz_o     = ~drive_en | ~(flags.up | flags.dn);
  assign cur_x4_o  = cur_sel_i;

  // R11: tri-state excludes any pump drive
  p_hiz_no_pump_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiz_o |-> (!pump_up_o && !pump_dn_o));
  // R6: forced tri-state wins
  p_force_z_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_z_i |-> (hiz_o && !pump_up_o && !pump_dn_o));
  // R7: power save keeps lock low
  p_pwr_no_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_save_i |=> !lock_o);
endmodule

// File: tb/test_pfd_ctrl.sv
module test_pfd_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ref_i = 0, fb_i = 0, polarity_i = 1, cur_sel_i = 0, force_z_i = 0, pwr_save_i = 0;
  logic pump_up_o, pump_dn_o, hiz_o, cur_x4_o, lock_o;
  int n_chk = 0, n_fail = 0;
  int n_up, n_dn, n_both, n_hiz;

  always #5 clk = ~clk;

  pfd_ctrl i_pfd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .fb_i(fb_i),
    .polarity_i(polarity_i), .cur_sel_i(cur_sel_i), .force_z_i(force_z_i),
    .pwr_save_i(pwr_save_i), .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o),
    .hiz_o(hiz_o), .cur_x4_o(cur_x4_o), .lock_o(lock_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one period of n cycles; each stream is high for 3 cycles from its start cycle
  task automatic run_period(input int ra, input int fa, input int n);
    n_up = 0; n_dn = 0; n_both = 0; n_hiz = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      ref_i = (c >= ra) && (c < ra + 3);
      fb_i  = (c >= fa) && (c < fa + 3);
      @(posedge clk); #2;
      if (pump_up_o && !pump_dn_o) n_up++;
      if (pump_dn_o && !pump_up_o) n_dn++;
      if (pump_up_o && pump_dn_o)  n_both++;
      if (hiz_o) begin
        n_hiz++;
        if (pump_up_o || pump_dn_o) check("R11 pump while hiz", 1, 0);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; ref_i = 0; fb_i = 0;
    repeat (2) @(negedge clk); rst_ni = 1;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    check("R3 reset hiz", hiz_o, 1);
    check("R3 reset pumps", pump_up_o | pump_dn_o, 0);
    check("R3 reset lock", lock_o, 0);
    run_period(99, 99, 4);
    check("R3 idle hiz cycles", n_hiz, 4);
  endtask

  task automatic t_cur_sel();
    @(negedge clk); cur_sel_i = 1; #1;
    check("R8 x4", cur_x4_o, 1);
    @(negedge clk); cur_sel_i = 0; #1;
    check("R8 x1", cur_x4_o, 0);
  endtask

  task automatic t_direction();
    polarity_i = 1;
    run_period(1, 6, 12);
    check("R1 ref lead up", n_up, 5);
    check("R1 ref lead dn", n_dn, 0);
    check("R5 overlap cycles", n_both, 2);
    run_period(6, 1, 12);
    check("R1 fb lead dn", n_dn, 5);
    check("R1 fb lead up", n_up, 0);
    polarity_i = 0;
    run_period(1, 6, 12);
    check("R2 ref lead dn", n_dn, 5);
    check("R2 ref lead up", n_up, 0);
    polarity_i = 1;
  endtask

  task automatic t_aligned();
    run_period(1, 1, 12);
    check("R5 coincident both", n_both, 2);
    check("R5 coincident single", n_up + n_dn, 0);
  endtask

  task automatic t_freq();
    do_reset();
    run_period(1, 99, 12);
    run_period(1, 99, 12);
    check("R4 up held across extra edges", n_up, 12);
    check("R4 no dn", n_dn, 0);
    run_period(1, 1, 12);
    check("R4 closes on fb edge", n_both, 2);
  endtask

  task automatic t_lock();
    do_reset();
    for (int p = 0; p < 3; p++) run_period(1, 1, 12);
    check("R9 not yet after 3", lock_o, 0);
    run_period(1, 1, 12);
    check("R9 locked after 4", lock_o, 1);
    run_period(1, 3, 12);
    check("R9 width at threshold", n_up, 2);
    check("R9 lock kept at threshold", lock_o, 1);
    run_period(1, 4, 12);
    check("R10 width over", n_up, 3);
    check("R10 lock dropped", lock_o, 0);
    for (int p = 0; p < 3; p++) run_period(1, 1, 12);
    check("R10 count restarted", lock_o, 0);
    run_period(1, 1, 12);
    check("R10 relock", lock_o, 1);
  endtask

  task automatic t_force_z();
    force_z_i = 1;
    run_period(1, 1, 12);
    check("R6 hiz", n_hiz, 12);
    check("R6 pumps", n_up + n_dn + n_both, 0);
    check("R6 lock kept", lock_o, 1);
    run_period(1, 6, 12);
    check("R6 hiz on lead", n_hiz, 12);
    check("R6 lock tracked", lock_o, 0);
    force_z_i = 0;
  endtask

  task automatic t_pwr_save();
    for (int p = 0; p < 4; p++) run_period(1, 1, 12);
    check("R7 locked before", lock_o, 1);
    run_period(1, 99, 6);
    check("R7 pending up", n_up, 5);
    pwr_save_i = 1;
    run_period(99, 99, 4);
    check("R7 hiz", n_hiz, 4);
    check("R7 lock cleared", lock_o, 0);
    pwr_save_i = 0;
    run_period(99, 99, 4);
    check("R7 pending cleared", n_hiz, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_cur_sel();
    t_direction();
    t_aligned();
    t_freq();
    t_lock();
    t_force_z();
    t_pwr_save();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule